// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is a bus-mapped controller for a single plane of embedded flash. Software writes a mode word with timing fields and a command word that carries a key byte, a page field and an operation code. The controller accepts a command only when the key matches and the code is known. It then holds its ready flag low for a fixed number of cycles and applies the operation when that time has run out.

Data reaches the array through a page buffer. Bus writes into the array window fill the buffer word by word. A page-write command copies the whole buffer over the selected page, so the old contents are erased automatically, and then sets the buffer back to all ones. The plane is split into lock regions of a fixed number of pages. A locked region refuses page writes, and any lock refuses erase-all. Set and clear commands change the lock bits and a few general-purpose non-volatile bits. Sticky flags record the end of a lock operation, lock violations and malformed commands. An irq output pulses whenever a command finishes or is rejected.

The storage is a behavioural register array that resets to the erased state. The lock bits and the general-purpose bits reset to zero.

Top module: `flash_cmd_unit`

## Requirements
- R1: After reset the status word reads 0x00000001: ready is set, and the lock bits, the general-purpose bits and all flags are zero. Status bits 7:4 always read zero. The mode word reads zero, every array word reads 0xFFFFFFFF, and the command register reads zero.
- R2: The mode register (register word 0) keeps only bits 23:16 and bit 8 of a write and returns them on read. All other bits read zero.
- R3: A command (register word 1) is accepted only when bits 31:24 equal 0x5A. The code is in bits 7:0 and the page field in bits 17:8. A wrong key sets status bit 3, leaves ready high and changes nothing else.
- R4: Codes 0x01 write-page, 0x02 set-lock, 0x04 clear-lock, 0x08 erase-all, 0x0B set-NVM and 0x0D clear-NVM are the only valid ones. Any other code is rejected with status bit 3. So is a page field at or beyond the page count for page and lock commands, and an index at or beyond the NVM-bit count for NVM commands.
- R5: An accepted command drives status bit 0 low for exactly PROG_CYCLES cycles, or ERASE_CYCLES for erase-all, and applies its effect on the edge where ready returns high. irq is high for one cycle after every completion or rejection.
- R6: A bus write into the array window (address bit ADDR_W-1 set) stores its data into page-buffer word (address mod PAGE_WORDS). Write-page copies all buffer words over the page and then refills the buffer with ones. Array reads return stored word (address mod total words).
- R7: Set-lock and clear-lock change lock bit (page field / PAGES_PER_REGION), which status bit 16+region shows. On completion status bit 1 (end of lock operation) is set.
- R8: A write-page into a locked region, or an erase-all while any lock bit is set, is rejected with status bit 2 and changes no array word.
- R9: Erase-all sets every array word to 0xFFFFFFFF.
- R10: Set-NVM and clear-NVM change bit (page field) of the general-purpose bits, which status bits 15:8 show.
- R11: A bus read of the status word (register word 2) clears bits 1, 2 and 3 after returning them. A flag set on the same edge as such a read stays set.
- R12: While ready is low, command writes and array-window writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | Access is a write |
| busAddr | input | ADDR_W | Word address; top bit selects the array window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on the address |
| irq | output | 1 | One-cycle pulse on completion or rejection |

## Verification
A wrong busy count shows up on the first status read where ready rises one cycle early or late. A lost or misrouted strobe shows up on the next read of the touched page, lock bit or general-purpose bit. Stale or uncleared flags appear in the status word at the second read after a rejection. The bench compares read data and irq with a behavioural model on every cycle, so any such divergence is reported in the cycle where it first becomes visible at the ports.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CmdKey       = 8'h5A;
  localparam logic [7:0] CodeWrPage   = 8'h01;
  localparam logic [7:0] CodeSetLock  = 8'h02;
  localparam logic [7:0] CodeClrLock  = 8'h04;
  localparam logic [7:0] CodeEraseAll = 8'h08;
  localparam logic [7:0] CodeSetNvm   = 8'h0B;
  localparam logic [7:0] CodeClrNvm   = 8'h0D;

  localparam logic [1:0] RegMode = 2'd0;
  localparam logic [1:0] RegCmd  = 2'd1;
  localparam logic [1:0] RegStat = 2'd2;

  // strobes from control to datapath, valid for one cycle at completion
  typedef struct packed {
    logic       commitPage;
    logic       eraseAll;
    logic       setLock;
    logic       clrLock;
    logic       setNvm;
    logic       clrNvm;
    logic [9:0] pageNum;
  } ctrl_strb_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_PAGES        = 64,
  parameter int PAGES_PER_REGION = 32,
  parameter int NUM_REGIONS      = 2,
  parameter int NUM_NVM          = 3,
  parameter int PROG_CYCLES      = 5,
  parameter int ERASE_CYCLES     = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWr,
  input  logic [7:0]             cmdKey,
  input  logic [9:0]             cmdPage,
  input  logic [7:0]             cmdCode,
  input  logic                   statRd,
  input  logic [NUM_REGIONS-1:0] lockBits,
  output logic                   ready,
  output logic                   eolFlag,
  output logic                   lockErr,
  output logic                   cmdErr,
  output logic                   irq,
  output ctrl_strb_t             strb
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int RIDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [CNT_W-1:0] busyCnt;
  logic [7:0]       opCode;
  logic [9:0]       opPage;
  logic             codeKnown, rangeOk, lockHit, lockBlock;
  logic             accept, rejFmt, rejLock, start, finish;
  logic [9:0]       regionFull;

  // R4: code and range decode
  always_comb begin
    codeKnown = 1'b1;
    rangeOk   = 1'b1;
    unique case (cmdCode)
      CodeWrPage, CodeSetLock, CodeClrLock: rangeOk = int'(cmdPage) < NUM_PAGES;
      CodeSetNvm, CodeClrNvm:               rangeOk = int'(cmdPage) < NUM_NVM;
      CodeEraseAll:                         rangeOk = 1'b1;
      default: begin
        codeKnown = 1'b0;
        rangeOk   = 1'b0;
      end
    endcase
  end

  assign regionFull = cmdPage / 10'(PAGES_PER_REGION);
  assign lockHit    = (int'(regionFull) < NUM_REGIONS) && lockBits[RIDX_W'(regionFull)];

  // R8: locked region blocks programming, any lock blocks erase-all
  assign lockBlock = ((cmdCode == CodeWrPage) && lockHit) ||
                     ((cmdCode == CodeEraseAll) && (|lockBits));

  // R3 / R12: only a keyed write while ready is considered
  assign accept  = cmdWr && ready;
  assign rejFmt  = accept && !((cmdKey == CmdKey) && codeKnown && rangeOk);
  assign rejLock = accept && !rejFmt && lockBlock;
  assign start   = accept && !rejFmt && !rejLock;
  assign finish  = !ready && (busyCnt == CNT_W'(1));

  // R5: busy window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready   <= 1'b1;
      busyCnt <= '0;
      opCode  <= '0;
      opPage  <= '0;
    end else if (start) begin
      ready   <= 1'b0;
      busyCnt <= (cmdCode == CodeEraseAll) ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
      opCode  <= cmdCode;
      opPage  <= cmdPage;
    end else if (finish) begin
      ready   <= 1'b1;
      busyCnt <= '0;
    end else if (!ready) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  // R7 / R11: sticky flags, a set wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eolFlag <= 1'b0;
      lockErr <= 1'b0;
      cmdErr  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (finish && ((opCode == CodeSetLock) || (opCode == CodeClrLock))) eolFlag <= 1'b1;
      else if (statRd)                                                    eolFlag <= 1'b0;
      if (rejLock)     lockErr <= 1'b1;
      else if (statRd) lockErr <= 1'b0;
      if (rejFmt)      cmdErr <= 1'b1;
      else if (statRd) cmdErr <= 1'b0;
      irq <= finish || rejFmt || rejLock;
    end
  end

  always_comb begin
    strb         = '0;
    strb.pageNum = opPage;
    if (finish) begin
      unique case (opCode)
        CodeWrPage:   strb.commitPage = 1'b1;
        CodeEraseAll: strb.eraseAll   = 1'b1;
        CodeSetLock:  strb.setLock    = 1'b1;
        CodeClrLock:  strb.clrLock    = 1'b1;
        CodeSetNvm:   strb.setNvm     = 1'b1;
        CodeClrNvm:   strb.clrNvm     = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int PAGE_WORDS       = 4,
  parameter int NUM_PAGES        = 64,
  parameter int PAGES_PER_REGION = 32,
  parameter int NUM_REGIONS      = 2,
  parameter int NUM_NVM          = 3,
  parameter int IDX_W            = 8,
  parameter int OFF_W            = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strb_t             strb,
  input  logic                   bufWr,
  input  logic [OFF_W-1:0]       bufOff,
  input  logic [31:0]            wrData,
  input  logic [IDX_W-1:0]       rdIdx,
  input  logic                   modeWr,
  input  logic [7:0]             modeCyc,
  input  logic                   modeWs,
  output logic [31:0]            arrWord,
  output logic [NUM_REGIONS-1:0] lockBits,
  output logic [NUM_NVM-1:0]     nvmBits,
  output logic [7:0]             modeCycQ,
  output logic                   modeWsQ
);

  localparam int TOTAL  = NUM_PAGES * PAGE_WORDS;
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int NIDX_W = (NUM_NVM > 1) ? $clog2(NUM_NVM) : 1;

  logic [31:0] mem  [TOTAL];
  logic [31:0] pbuf [PAGE_WORDS];
  logic [RIDX_W-1:0] lockIdx;
  logic [NIDX_W-1:0] nvmIdx;

  assign lockIdx = RIDX_W'(strb.pageNum / 10'(PAGES_PER_REGION));
  assign nvmIdx  = NIDX_W'(strb.pageNum);

  // R6 / R9: array contents, erased state is all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
    end else if (strb.eraseAll) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
    end else if (strb.commitPage) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        mem[IDX_W'(int'(strb.pageNum) * PAGE_WORDS + w)] <= pbuf[w];
    end
  end

  // R6: page buffer, refilled with ones after a commit
  generate
    for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_buf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   pbuf[w] <= '1;
        else if (strb.commitPage)                    pbuf[w] <= '1;
        else if (bufWr && (bufOff == OFF_W'(w)))     pbuf[w] <= wrData;
      end
    end
  endgenerate

  // R7 / R10: lock and general-purpose bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits <= '0;
      nvmBits  <= '0;
    end else begin
      if (strb.setLock) lockBits[lockIdx] <= 1'b1;
      if (strb.clrLock) lockBits[lockIdx] <= 1'b0;
      if (strb.setNvm)  nvmBits[nvmIdx]   <= 1'b1;
      if (strb.clrNvm)  nvmBits[nvmIdx]   <= 1'b0;
    end
  end

  // R2: timing fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCycQ <= '0;
      modeWsQ  <= 1'b0;
    end else if (modeWr) begin
      modeCycQ <= modeCyc;
      modeWsQ  <= modeWs;
    end
  end

  assign arrWord = mem[rdIdx];

endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import flash_cmd_pkg::*;
#(
  parameter  int PAGE_WORDS       = 4,
  parameter  int NUM_PAGES        = 64,
  parameter  int PAGES_PER_REGION = 32,
  parameter  int NUM_NVM          = 3,
  parameter  int PROG_CYCLES      = 5,
  parameter  int ERASE_CYCLES     = 12,
  localparam int NUM_REGIONS      = NUM_PAGES / PAGES_PER_REGION,
  localparam int IDX_W            = $clog2(NUM_PAGES * PAGE_WORDS),
  localparam int OFF_W            = $clog2(PAGE_WORDS),
  localparam int ADDR_W           = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  logic isArr, regHit;
  logic [1:0] regSel;
  logic cmdWr, statRd, modeWr, bufWr;
  logic ready, eolFlag, lockErr, cmdErr;
  ctrl_strb_t strb;
  logic [31:0] arrWord, statusWord;
  logic [NUM_REGIONS-1:0] lockBits;
  logic [NUM_NVM-1:0] nvmBits;
  logic [7:0] modeCycQ;
  logic modeWsQ;

  assign isArr  = busAddr[ADDR_W-1];
  assign regHit = !isArr && (busAddr[IDX_W-1:2] == '0);
  assign regSel = busAddr[1:0];
  assign cmdWr  = busValid && busWrite && regHit && (regSel == RegCmd);
  assign statRd = busValid && !busWrite && regHit && (regSel == RegStat);
  assign modeWr = busValid && busWrite && regHit && (regSel == RegMode);
  assign bufWr  = busValid && busWrite && isArr && ready;   // R12

  flash_cmd_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION),
    .NUM_REGIONS(NUM_REGIONS), .NUM_NVM(NUM_NVM),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr),
    .cmdKey(busWdata[31:24]), .cmdPage(busWdata[17:8]), .cmdCode(busWdata[7:0]),
    .statRd(statRd), .lockBits(lockBits),
    .ready(ready), .eolFlag(eolFlag), .lockErr(lockErr), .cmdErr(cmdErr),
    .irq(irq), .strb(strb)
  );

  flash_cmd_dp #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
    .PAGES_PER_REGION(PAGES_PER_REGION), .NUM_REGIONS(NUM_REGIONS),
    .NUM_NVM(NUM_NVM), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .bufWr(bufWr), .bufOff(busAddr[OFF_W-1:0]), .wrData(busWdata),
    .rdIdx(busAddr[IDX_W-1:0]),
    .modeWr(modeWr), .modeCyc(busWdata[23:16]), .modeWs(busWdata[8]),
    .arrWord(arrWord), .lockBits(lockBits), .nvmBits(nvmBits),
    .modeCycQ(modeCycQ), .modeWsQ(modeWsQ)
  );

  // R1 / R7 / R10: status word layout
  always_comb begin
    statusWord = '0;
    statusWord[0] = ready;
    statusWord[1] = eolFlag;
    statusWord[2] = lockErr;
    statusWord[3] = cmdErr;
    statusWord[8 +: NUM_NVM]      = nvmBits;
    statusWord[16 +: NUM_REGIONS] = lockBits;
  end

  always_comb begin
    busRdata = '0;
    if (isArr) begin
      busRdata = arrWord;
    end else if (regHit) begin
      unique case (regSel)
        RegMode: begin
          busRdata[23:16] = modeCycQ;
          busRdata[8]     = modeWsQ;
        end
        RegStat: busRdata = statusWord;
        default: busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic [7:0] cmdKey,
  input logic       statRd,
  input logic [3:0] rdSpare,
  input logic       irq,
  input logic       ready,
  input ctrl_strb_t strb
);

  logic strbAny;
  assign strbAny = strb.commitPage | strb.eraseAll | strb.setLock |
                   strb.clrLock | strb.setNvm | strb.clrNvm;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.commitPage, strb.eraseAll, strb.setLock, strb.clrLock, strb.setNvm, strb.clrNvm})); // R5

  AST_DONE_RAISES_READY: assert property (@(posedge clk) disable iff (!rstN)
    strbAny |=> ready); // R5

  AST_DONE_PULSES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    strbAny |=> irq); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !strbAny) |=> !ready); // R5

  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(cmdWr && (cmdKey == CmdKey))); // R3

  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> (rdSpare == 4'b0000)); // R1

  AST_BUSY_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> $stable(strb.pageNum)); // R12

endmodule

bind flash_cmd_unit flash_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdKey(busWdata[31:24]),
  .statRd(statRd), .rdSpare(busRdata[7:4]), .irq(irq), .ready(ready), .strb(strb)
);

// File: tb/sim_flash_cmd_unit.sv
module sim_flash_cmd_unit;

  localparam int PW = 4, NP = 64, PPR = 32, NN = 3, PC = 5, EC = 12;
  localparam int TOT = NP * PW;
  localparam logic [8:0] A_MODE = 9'h000, A_CMD = 9'h001, A_STAT = 9'h002, A_ARR = 9'h100;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [8:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq;

  flash_cmd_unit #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .PAGES_PER_REGION(PPR),
                   .NUM_NVM(NN), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] memM [TOT];
  logic [31:0] bufM [PW];
  int lockM, nvmM, modeM, cntM, opM, pgM;
  bit eolM, lerrM, cerrM, busyM, irqM;

  task automatic modelReset();
    for (int i = 0; i < TOT; i++) memM[i] = '1;
    for (int i = 0; i < PW; i++) bufM[i] = '1;
    lockM = 0; nvmM = 0; modeM = 0; cntM = 0; opM = 0; pgM = 0;
    eolM = 0; lerrM = 0; cerrM = 0; busyM = 0; irqM = 0;
  endtask

  function automatic logic [31:0] statusM();
    return (32'(lockM) << 16) | (32'(nvmM) << 8) | (32'(cerrM) << 3) |
           (32'(lerrM) << 2) | (32'(eolM) << 1) | 32'(!busyM);
  endfunction

  function automatic logic [31:0] expRd(logic [8:0] a);
    if (a[8]) return memM[int'(a[7:0])];
    if (a[7:2] != 0) return 32'h0;
    case (a[1:0])
      2'd0: return 32'(modeM);
      2'd2: return statusM();
      default: return 32'h0;
    endcase
  endfunction

  task automatic applyOp();
    case (opM)
      8'h01: begin
        for (int w = 0; w < PW; w++) begin memM[pgM*PW + w] = bufM[w]; bufM[w] = '1; end
      end
      8'h02: lockM = lockM | (1 << (pgM / PPR));
      8'h04: lockM = lockM & ~(1 << (pgM / PPR));
      8'h08: for (int i = 0; i < TOT; i++) memM[i] = '1;
      8'h0B: nvmM = nvmM | (1 << pgM);
      8'h0D: nvmM = nvmM & ~(1 << pgM);
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else begin
      bit wasBusy, irqN;
      wasBusy = busyM; irqN = 0;
      if (busValid && !busWrite && busAddr == A_STAT) begin eolM = 0; lerrM = 0; cerrM = 0; end
      if (busyM) begin
        if (cntM == 1) begin
          applyOp(); busyM = 0; irqN = 1;
          if (opM == 8'h02 || opM == 8'h04) eolM = 1;
        end else cntM--;
      end
      if (busValid && busWrite) begin
        if (busAddr[8]) begin
          if (!wasBusy) bufM[int'(busAddr[1:0])] = busWdata;
        end else if (busAddr == A_MODE) modeM = int'(busWdata & 32'h00FF0100);
        else if (busAddr == A_CMD && !wasBusy) begin
          int code, pg; bit known, rng;
          code = int'(busWdata[7:0]); pg = int'(busWdata[17:8]);
          known = (code == 1 || code == 2 || code == 4 || code == 8 || code == 'h0B || code == 'h0D);
          rng = (code == 8) ? 1 : ((code == 'h0B || code == 'h0D) ? (pg < NN) : (pg < NP));
          if (!(busWdata[31:24] == 8'h5A && known && rng)) begin cerrM = 1; irqN = 1; end
          else if ((code == 1 && ((lockM >> (pg / PPR)) & 1) == 1) || (code == 8 && lockM != 0)) begin
            lerrM = 1; irqN = 1;
          end else begin
            busyM = 1; cntM = (code == 8) ? EC : PC; opM = code; pgM = pg;
          end
        end
      end
      irqM = irqN;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      logic [31:0] e;
      e = expRd(busAddr);
      checks++;
      if (busRdata !== e) begin
        errors++;
        $display("FAIL %s: addr %h rdata actual %h expected %h", curReq, busAddr, busRdata, e);
      end
      checks++;
      if (irq !== irqM) begin
        errors++;
        $display("FAIL %s: irq actual %0b expected %0b", curReq, irq, irqM);
      end
    end
  end

  task automatic drive(input logic v, input logic w, input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); busValid = v; busWrite = w; busAddr = a; busWdata = d;
  endtask
  task automatic wr(input logic [8:0] a, input logic [31:0] d); drive(1'b1, 1'b1, a, d); endtask
  task automatic rd(input logic [8:0] a); drive(1'b1, 1'b0, a, 32'h0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) drive(1'b0, 1'b0, A_STAT, 32'h0); endtask
  task automatic poll(input int n); for (int i = 0; i < n; i++) rd(A_STAT); endtask
  task automatic rdPage(input int p); for (int w = 0; w < PW; w++) rd(A_ARR + 9'(p*PW + w)); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; idle(2); rd(A_STAT); rd(A_MODE); rd(A_CMD); rd(A_ARR); rd(A_ARR + 9'd255);
    curReq = "R2"; wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE); wr(A_MODE, 32'h0012_0100); rd(A_MODE);
    wr(A_MODE, 32'hFF00_00FF); rd(A_MODE);
    curReq = "R3"; wr(A_CMD, 32'hA500_0501); rd(A_STAT);
    curReq = "R11"; rd(A_STAT);
    curReq = "R4"; wr(A_CMD, 32'h5A00_0503); rd(A_STAT); wr(A_CMD, 32'h5A00_4001); rd(A_STAT);
    wr(A_CMD, 32'h5A00_030B); rd(A_STAT); wr(A_CMD, 32'h5A00_4002); rd(A_STAT);
    curReq = "R6"; wr(A_ARR + 9'd0, 32'h1111_0000); wr(A_ARR + 9'd1, 32'h2222_0001);
    wr(A_ARR + 9'd2, 32'h3333_0002); wr(A_ARR + 9'h17, 32'h4444_0003);
    wr(A_CMD, 32'h5A00_0501); poll(7); rdPage(5);
    wr(A_ARR + 9'd1, 32'hCAFE_F00D); wr(A_CMD, 32'h5A00_0501); poll(7); rdPage(5);
    curReq = "R12"; wr(A_ARR + 9'd0, 32'hABCD_0006); wr(A_CMD, 32'h5A00_0601);
    wr(A_CMD, 32'h5A00_0701); wr(A_ARR + 9'd1, 32'hDEAD_BEEF); poll(5);
    rdPage(6); rdPage(7); wr(A_CMD, 32'h5A00_0801); poll(7); rdPage(8);
    curReq = "R7"; wr(A_CMD, 32'h5A00_2802); poll(7); rd(A_STAT);
    curReq = "R8"; wr(A_ARR + 9'd0, 32'h5555_AAAA); wr(A_CMD, 32'h5A00_2101); rd(A_STAT);
    rdPage(33); wr(A_CMD, 32'h5A00_0008); rd(A_STAT); rdPage(5);
    wr(A_CMD, 32'h5A00_1F01); poll(7); rdPage(31);
    curReq = "R7"; wr(A_CMD, 32'h5A00_3F04); poll(7);
    curReq = "R5 R9"; wr(A_CMD, 32'h5A00_0008); poll(14); rdPage(5); rdPage(31);
    curReq = "R10"; wr(A_CMD, 32'h5A00_020B); poll(7); wr(A_CMD, 32'h5A00_000B); poll(7);
    wr(A_CMD, 32'h5A00_020D); poll(7);
    curReq = "R11"; wr(A_CMD, 32'h5A00_0002); poll(8); idle(2); rd(A_STAT);
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule